// File: doc/BRIEF.md
# Dual-Pipeline Indexed Register Access Controller

This block sits between a host I/O port and a set of index/data register groups that exist once for display pipeline A and once for display pipeline B. A host reaches an indexed group in two steps. It writes an index to the group's index port, then reads or writes the group's data port. A five-bit pipeline control word decides which pipeline's index drives the access, which copy of the data registers receives a write, and which copy answers a read. The block also holds one plain scratch register, which stands for the directly addressed registers.

There are two classes of indexed group. In the general group, the index write enable and the index pipeline select apply. Index 0 to NREG-1 reaches a per-pipeline register, and the next NSHARED indices reach a single shared copy. In the special group, the enable and the select are ignored. The write mode field writes index values and data into the A shadow, the B shadow or both at once. The host port is a synchronous strobe interface. Each read strobe returns exactly one response, with `host_rvalid` high in the next cycle. The response channel has no ready signal, so the host must accept every response in the cycle it appears and cannot apply back-pressure. Write strobes are accepted in every cycle.

Top module: `dpx_access_ctrl`

## Requirements
- R1: After reset the control word, all four index registers, all data registers, the scratch register, `host_rdata` and `host_rvalid` are zero.
- R2: Port 0 is the control word, and only write-data bits 4:0 are stored: bit 4 enable, bit 3 index select, bit 2 read copy, bits 1:0 write mode. A read of port 0 returns the stored bits, with bits 7:5 as zero.
- R3: A write to the general index port (port 1) while bit 4 is 0 is dropped, and both general indices keep their values.
- R4: With bit 4 set, a general index write goes only to the index of the pipeline chosen by bit 3 (0 = A, 1 = B). A read of port 1 returns that pipeline's index whatever bit 4 holds.
- R5: General data accesses (port 2) use the index of the pipeline chosen by bit 3, whichever register copy is accessed.
- R6: For a general data index below NREG, a write goes to copy A when bits 1:0 are 00, to copy B when they are 01, and to both copies when they are 10 or 11. A read returns copy A when bit 2 is 0 and copy B when it is 1.
- R7: A general index from NREG to NREG+NSHARED-1 reaches one shared register. It is written once for any write mode and read for any value of bit 2.
- R8: A data index beyond the last valid register (general: NREG+NSHARED or more; special: NREG or more) ignores writes and reads as zero.
- R9: Special index writes (port 3) ignore bits 4 and 3. They go to shadow A, shadow B or both, as bits 1:0 select in R6. A read of port 3 returns the shadow selected by bit 2.
- R10: A special data write (port 4) goes to each copy selected by bits 1:0, at that copy's own index. A special data read returns the copy selected by bit 2, at that copy's own index.
- R11: The scratch register (port 5) is read and written directly, and no control bit affects it.
- R12: `host_rvalid` is high exactly in the cycle after a read strobe. The read data reflect state before any write in the same cycle. Ports 6 and 7 ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Host port select |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Read data, held between responses |
| host_rvalid | output | 1 | Read response valid, one cycle after host_rd |

## Verification
The hardest case to reach is the one where the two pipelines' indices differ while a data access runs in a mixed setting. Examples are reading copy B through pipeline A's index, or a special write in both mode that lands at two different addresses. The stimulus reaches this by loading each pipeline's index separately through single-copy write modes. It then changes only the control word between data accesses, so each read shows which index and which copy the block actually used. Shared and out-of-range indices are reached the same way, and each read is checked against an expected-value queue.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] PORT_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] PORT_GIDX  = 3'd1;
  localparam logic [ADDR_W-1:0] PORT_GDATA = 3'd2;
  localparam logic [ADDR_W-1:0] PORT_SIDX  = 3'd3;
  localparam logic [ADDR_W-1:0] PORT_SDATA = 3'd4;
  localparam logic [ADDR_W-1:0] PORT_SCR   = 3'd5;

  localparam int CTL_W = 5;

  typedef struct packed {
    logic       idx_wen;   // bit 4
    logic       pipe_sel;  // bit 3
    logic       rd_copy;   // bit 2
    logic [1:0] wr_mode;   // bits 1:0
  } pctl_t;

  function automatic logic mode_hits_a(input logic [1:0] m);
    return m != 2'b01;
  endfunction

  function automatic logic mode_hits_b(input logic [1:0] m);
    return m != 2'b00;
  endfunction
endpackage

// File: rtl/dpx_ctrl_reg.sv
module dpx_ctrl_reg
  import dpx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          scr_we,
  input  logic [DW-1:0] wdata,
  output pctl_t         ctl,
  output logic [DW-1:0] scr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      scr <= '0;
    end else begin
      if (ctl_we) ctl <= pctl_t'(wdata[CTL_W-1:0]);
      if (scr_we) scr <= wdata;
    end
  end

  // R11: scratch changes only through its own write strobe
  a_r11_scr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_we |=> $stable(scr));

  // R2: control word takes the low write-data bits
  a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl == pctl_t'($past(wdata[CTL_W-1:0])));
endmodule

// File: rtl/dpx_index_pair.sv
module dpx_index_pair #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic          we_b,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] idx_a,
  output logic [DW-1:0] idx_b
);
  localparam int NCOPY = 2;

  logic [NCOPY-1:0] we;
  logic [DW-1:0]    idx_q [NCOPY];

  assign we = {we_b, we_a};

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx_q[c] <= '0;
      else if (we[c]) idx_q[c] <= wdata;
    end
  end

  assign idx_a = idx_q[0];
  assign idx_b = idx_q[1];

  // R9: a dual write leaves both shadows equal
  a_r9_both_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && we_b) |=> (idx_a == idx_b));
endmodule

// File: rtl/dpx_reg_bank.sv
module dpx_reg_bank #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(raddr) < DEPTH) rdata = mem[raddr];
  end

  // R6: a write is visible at its address in the next cycle
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(waddr) < DEPTH) |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/dpx_access_ctrl.sv
module dpx_access_ctrl
  import dpx_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NREG    = 16,
  parameter int NSHARED = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_rvalid
);
  localparam int RA_W   = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int SA_W   = (NSHARED > 1) ? $clog2(NSHARED) : 1;
  localparam int G_LAST = NREG + NSHARED;
  localparam int NCOPY  = 2;

  pctl_t         ctl;
  logic [DW-1:0] scr;
  logic [DW-1:0] gidx_a, gidx_b, sidx_a, sidx_b;

  // port decode
  logic wr_ctl, wr_scr, wr_gidx, wr_gdata, wr_sidx, wr_sdata;
  assign wr_ctl   = host_wr && (host_addr == PORT_CTRL);
  assign wr_scr   = host_wr && (host_addr == PORT_SCR);
  assign wr_gidx  = host_wr && (host_addr == PORT_GIDX);
  assign wr_gdata = host_wr && (host_addr == PORT_GDATA);
  assign wr_sidx  = host_wr && (host_addr == PORT_SIDX);
  assign wr_sdata = host_wr && (host_addr == PORT_SDATA);

  logic hit_a, hit_b;
  assign hit_a = mode_hits_a(ctl.wr_mode);
  assign hit_b = mode_hits_b(ctl.wr_mode);

  dpx_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(wr_ctl), .scr_we(wr_scr),
    .wdata(host_wdata), .ctl(ctl), .scr(scr)
  );

  // general group index: gated by enable, routed by pipe select
  dpx_index_pair #(.DW(DW)) u_gidx (
    .clk(clk), .rst_n(rst_n),
    .we_a(wr_gidx && ctl.idx_wen && !ctl.pipe_sel),
    .we_b(wr_gidx && ctl.idx_wen &&  ctl.pipe_sel),
    .wdata(host_wdata), .idx_a(gidx_a), .idx_b(gidx_b)
  );

  // special group index: shadows chosen by write mode
  dpx_index_pair #(.DW(DW)) u_sidx (
    .clk(clk), .rst_n(rst_n),
    .we_a(wr_sidx && hit_a), .we_b(wr_sidx && hit_b),
    .wdata(host_wdata), .idx_a(sidx_a), .idx_b(sidx_b)
  );

  // general data path
  logic [DW-1:0] g_ix;
  logic          g_local, g_shared;
  assign g_ix     = ctl.pipe_sel ? gidx_b : gidx_a;
  assign g_local  = int'(g_ix) < NREG;
  assign g_shared = !g_local && (int'(g_ix) < G_LAST);

  logic [SA_W-1:0] sh_addr;
  logic [DW-1:0]   sh_rd;
  assign sh_addr = SA_W'(g_ix - DW'(NREG));

  dpx_reg_bank #(.DEPTH(NSHARED), .DW(DW)) u_shared (
    .clk(clk), .rst_n(rst_n), .we(wr_gdata && g_shared),
    .waddr(sh_addr), .wdata(host_wdata), .raddr(sh_addr), .rdata(sh_rd)
  );

  logic [NCOPY-1:0] copy_hit;
  logic [DW-1:0]    s_ix [NCOPY];
  logic [DW-1:0]    g_rd [NCOPY];
  logic [DW-1:0]    s_rd [NCOPY];
  assign copy_hit = {hit_b, hit_a};
  assign s_ix[0]  = sidx_a;
  assign s_ix[1]  = sidx_b;

  for (genvar c = 0; c < NCOPY; c++) begin : g_pipe
    logic s_ok;
    assign s_ok = int'(s_ix[c]) < NREG;

    dpx_reg_bank #(.DEPTH(NREG), .DW(DW)) u_gen (
      .clk(clk), .rst_n(rst_n), .we(wr_gdata && g_local && copy_hit[c]),
      .waddr(g_ix[RA_W-1:0]), .wdata(host_wdata),
      .raddr(g_ix[RA_W-1:0]), .rdata(g_rd[c])
    );

    dpx_reg_bank #(.DEPTH(NREG), .DW(DW)) u_spec (
      .clk(clk), .rst_n(rst_n), .we(wr_sdata && s_ok && copy_hit[c]),
      .waddr(s_ix[c][RA_W-1:0]), .wdata(host_wdata),
      .raddr(s_ix[c][RA_W-1:0]), .rdata(s_rd[c])
    );
  end

  // read mux
  logic [DW-1:0] rd_mux;
  logic          rsel;
  assign rsel = ctl.rd_copy;

  always_comb begin
    rd_mux = '0;
    unique case (host_addr)
      PORT_CTRL:  rd_mux = DW'(ctl);
      PORT_GIDX:  rd_mux = g_ix;
      PORT_SIDX:  rd_mux = rsel ? sidx_b : sidx_a;
      PORT_SCR:   rd_mux = scr;
      PORT_GDATA: begin
        if (g_local)       rd_mux = g_rd[rsel];
        else if (g_shared) rd_mux = sh_rd;
      end
      PORT_SDATA: begin
        if (int'(s_ix[rsel]) < NREG) rd_mux = s_rd[rsel];
      end
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_mux;
    end
  end

  // R3: disabled index write leaves both general indices intact
  a_r3_idx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gidx && !ctl.idx_wen) |=> ($stable(gidx_a) && $stable(gidx_b)));

  // R4: enabled write with select B touches only pipeline B's index
  a_r4_route_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gidx && ctl.idx_wen && ctl.pipe_sel) |=>
      (gidx_b == $past(host_wdata) && $stable(gidx_a)));

  // R4: enabled write with select A touches only pipeline A's index
  a_r4_route_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gidx && ctl.idx_wen && !ctl.pipe_sel) |=>
      (gidx_a == $past(host_wdata) && $stable(gidx_b)));

  // R9: B-only special index write leaves shadow A alone
  a_r9_spec_b_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sidx && ctl.wr_mode == 2'b01) |=> $stable(sidx_a));

  // R12: one response, one cycle after each read strobe
  a_r12_resp_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !host_rvalid);
endmodule

// File: tb/dpx_access_ctrl_tb.sv
module dpx_access_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_rvalid;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpx_access_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] mon_e;
  string      mon_t;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic setc(input logic [7:0] d);
    wr(3'd0, d);
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic rdwr(input logic [2:0] a, input logic [7:0] d,
                      input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_rd = 1'b1; host_wr = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
  endtask

  // monitor: pop expected responses as the design produces them
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected response", 8'h01, 8'h00);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        check(mon_t, host_rdata, mon_e);
      end
    end
  end

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", {7'b0, host_rvalid}, 8'h00);
    check("R1 rdata in reset", host_rdata, 8'h00);
    rst_n = 1'b1;

    rd(3'd0, 8'h00, "R1 ctrl");
    rd(3'd1, 8'h00, "R1 gidx");
    rd(3'd3, 8'h00, "R1 sidx");
    rd(3'd2, 8'h00, "R1 gdata");

    setc(8'hFF);
    rd(3'd0, 8'h1F, "R2 upper bits zero");
    setc(8'h00);

    wr(3'd1, 8'd5);
    rd(3'd1, 8'h00, "R3 disabled index write dropped");

    setc(8'h10); wr(3'd1, 8'd3);
    setc(8'h18); rd(3'd1, 8'd0, "R4 B index untouched");
    wr(3'd1, 8'd7); rd(3'd1, 8'd7, "R4 B index written");
    setc(8'h08); rd(3'd1, 8'd7, "R4 read with enable off");
    setc(8'h00); rd(3'd1, 8'd3, "R4 A index");

    wr(3'd2, 8'hA1);
    setc(8'h04); rd(3'd2, 8'h00, "R6 A-only leaves B copy");
    setc(8'h00); rd(3'd2, 8'hA1, "R6 A copy written");
    setc(8'h08); rd(3'd2, 8'h00, "R5 B index selects reg 7");
    setc(8'h09); wr(3'd2, 8'hB7);
    setc(8'h0C); rd(3'd2, 8'hB7, "R6 B-only write");
    setc(8'h08); rd(3'd2, 8'h00, "R6 B-only leaves A copy");
    setc(8'h04); rd(3'd2, 8'h00, "R5 A index reads B copy reg 3");
    setc(8'h03); wr(3'd2, 8'h33);
    setc(8'h04); rd(3'd2, 8'h33, "R6 both mode B copy");
    setc(8'h00); rd(3'd2, 8'h33, "R6 both mode A copy");
    setc(8'h0A); wr(3'd2, 8'h77);
    setc(8'h08); rd(3'd2, 8'h77, "R6 mode 10 A copy");
    setc(8'h0C); rd(3'd2, 8'h77, "R6 mode 10 B copy");

    setc(8'h10); wr(3'd1, 8'd17);
    setc(8'h18); wr(3'd1, 8'd17);
    setc(8'h00); wr(3'd2, 8'h5E);
    setc(8'h0C); rd(3'd2, 8'h5E, "R7 shared via B index");
    setc(8'h08); rd(3'd2, 8'h5E, "R7 shared read copy A");

    setc(8'h10); wr(3'd1, 8'd30);
    setc(8'h03); wr(3'd2, 8'h99);
    rd(3'd2, 8'h00, "R8 general out of range reads zero");
    setc(8'h08); rd(3'd2, 8'h5E, "R8 shared untouched");

    setc(8'h19); wr(3'd3, 8'd4);
    setc(8'h04); rd(3'd3, 8'd4, "R9 B shadow written");
    setc(8'h00); rd(3'd3, 8'd0, "R9 A shadow untouched");
    wr(3'd3, 8'd2); rd(3'd3, 8'd2, "R9 enable bit ignored");
    setc(8'h03); wr(3'd3, 8'd9);
    rd(3'd3, 8'd9, "R9 both shadows A");
    setc(8'h07); rd(3'd3, 8'd9, "R9 both shadows B");

    setc(8'h01); wr(3'd3, 8'd6);
    setc(8'h03); wr(3'd4, 8'hC3);
    setc(8'h00); wr(3'd4, 8'h11);
    rd(3'd4, 8'h11, "R10 A copy own index");
    setc(8'h04); rd(3'd4, 8'hC3, "R10 B copy own index");
    setc(8'h01); wr(3'd3, 8'd9);
    setc(8'h04); rd(3'd4, 8'h00, "R10 B reg 9 not written");
    setc(8'h00); wr(3'd3, 8'd20);
    wr(3'd4, 8'h44);
    rd(3'd4, 8'h00, "R8 special out of range reads zero");

    wr(3'd5, 8'h5A);
    setc(8'h18); rd(3'd5, 8'h5A, "R11 scratch ignores select");
    setc(8'h08); wr(3'd5, 8'hA5);
    rd(3'd5, 8'hA5, "R11 scratch write");

    wr(3'd6, 8'hFF);
    rd(3'd6, 8'h00, "R12 unmapped reads zero");
    rd(3'd0, 8'h08, "R12 unmapped write no effect");
    rdwr(3'd5, 8'h3C, 8'hA5, "R12 read before same-cycle write");
    rd(3'd5, 8'h3C, "R12 write landed");

    repeat (3) @(negedge clk);
    check("R12 all responses seen", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule